// File: doc/BRIEF.md
# Block-Alternating DMA Pattern Checker

This block drives a buffer-transfer test over a target memory, window by window. Each window is a 4096-byte buffer. For every window the block runs four passes in a fixed order:
1. It streams a selected test pattern out toward the target.
2. It checks the bytes read back from the target.
3. It streams zeros that clear the local receive buffer.
4. It checks the bytes that the receive transfer brings back.

The pattern is computed from a 3-bit selector and the byte offset within the buffer, so no pattern storage is needed. The selector offers:
- runs of 16 or 32 bytes that alternate between all-zero and all-one;
- a constant all-zero or all-one fill;
- two alternating word patterns.

The DMA engine and the memories sit outside the block. They connect through two byte-wide valid/ready streams.

On the outgoing stream the block owns `tx_valid`. While the sink holds `tx_ready` low, `tx_valid` stays high and `tx_data` does not change. On the incoming stream the block owns `rx_ready`. A byte is consumed only in a cycle where `rx_valid` and `rx_ready` are both high. Either side may stall for any number of cycles without data loss.

The first data mismatch is kept, together with:
- a direction code;
- the absolute offset in the target range;
- the expected byte and the received byte.

Control is a single start pulse with a pattern selector and a window count. Completion is a one-cycle done pulse.

Top module: `dma_pattern_checker`

## Requirements
- R1: The pattern byte at buffer offset `o` is chosen by `pat_sel`, and `pat_sel` is latched when a start is accepted. Codes 0 and 1 alternate 16-byte runs: code 0 starts with 0x00, code 1 starts with 0xFF. Codes 2 and 3 alternate 32-byte runs: code 2 starts with 0x00, code 3 starts with 0xFF. Code 4 is all 0x00 and code 5 is all 0xFF.
- R2: Code 6 repeats the word 0xAA55AA55 and code 7 repeats the word 0x55AA55AA. Both are emitted little-endian. Code 6 therefore gives the bytes 55 AA 55 AA starting at every 4-byte boundary, and code 7 gives AA 55 AA 55.
- R3: Each window runs four passes of exactly 4096 handshakes in this order:
  - pattern bytes out on tx, with `tx_zero`=0;
  - target read-back in on rx;
  - 0x00 bytes out on tx, with `tx_zero`=1;
  - host receive data in on rx.
  The tx and rx streams are never active in the same cycle.
- R4: A byte moves only in a cycle where valid and ready are both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R5: A run covers `num_windows` windows in increasing order, and `num_windows` is latched at start. Window `w`, offset `o` corresponds to target offset `w*4096+o`.
- R6: `done` is high for one cycle. It rises in the cycle after the final rx handshake of the last window, and `busy` is low in that same cycle. A start with `num_windows`=0 makes no transfer and gives `done` in the cycle after the start.
- R7: A mismatch is reported on `err_code`. The value 2'b01 means the target read-back pass and 2'b10 means the host receive pass; 2'b00 means no mismatch. With it come `err_offset` (the target offset), `err_expected` (the pattern byte) and `err_received` (the received byte).
- R8: Only the first mismatch of a run is kept. Later mismatches leave all error outputs unchanged until the next accepted start.
- R9: A start while idle clears the error outputs. A start while `busy` is high is ignored: it does not change the pattern, the window count or the run.
- R10: After reset, `busy`, `done`, `tx_valid`, `rx_ready` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| pat_sel | input | 3 | Pattern code |
| num_windows | input | WIN_W (8) | Number of 4096-byte windows to cover |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing sink ready |
| tx_data | output | 8 | Outgoing byte |
| tx_zero | output | 1 | Outgoing byte belongs to the receive-buffer clear pass |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block accepts incoming bytes |
| rx_data | input | 8 | Incoming byte |
| err_code | output | 2 | First mismatch direction (00 none, 01 target, 10 host) |
| err_offset | output | WIN_W+12 (20) | Target offset of the first mismatch |
| err_expected | output | 8 | Expected byte at the first mismatch |
| err_received | output | 8 | Received byte at the first mismatch |

## Verification
The assertions assume that `start` is a clean synchronous pulse and that the stream partners obey valid/ready. In particular, they assume a sink may drop `tx_ready` at any time, and that `rx_data` is only meaningful in a cycle where `rx_valid` is high.

The stimulus keeps within these assumptions by driving every input half a cycle away from the active edge. It stalls `tx_ready` and `rx_valid` in fixed periodic slots. It only ever issues start as a single-cycle pulse, including the one deliberately issued in the middle of a run. Mismatches are injected only by flipping bits of the returned data, never by breaking the handshake.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FILL  = 3'd1,
    PH_VTGT  = 3'd2,
    PH_CLEAR = 3'd3,
    PH_VHOST = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    EC_NONE  = 2'b00,
    EC_TXDIR = 2'b01,
    EC_RXDIR = 2'b10
  } errcode_t;

  localparam int unsigned NUM_PATTERNS = 8;
  localparam int unsigned SEL_W        = 3;
endpackage

// File: rtl/dpc_pattern.sv
module dpc_pattern
  import dpc_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [OFF_W-1:0] off,
  output logic [7:0]       byte_o
);
  logic [7:0] cand [NUM_PATTERNS];

  for (genvar g = 0; g < NUM_PATTERNS; g++) begin : g_pat
    if (g < 4) begin : g_run
      localparam int  RUN_BIT = (g < 2) ? 4 : 5;
      localparam bit  INV     = (g % 2) == 1;
      assign cand[g] = (off[RUN_BIT] ^ INV) ? 8'hFF : 8'h00;
    end else if (g < 6) begin : g_flat
      localparam logic [7:0] FLAT = (g == 5) ? 8'hFF : 8'h00;
      assign cand[g] = FLAT;
    end else begin : g_word
      localparam bit HI_FIRST = (g == 7);
      assign cand[g] = (off[0] ^ HI_FIRST) ? 8'hAA : 8'h55;
    end
  end

  assign byte_o = cand[sel];
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] pat_sel,
  input  logic [WIN_W-1:0] num_windows,
  input  logic             tx_ready,
  input  logic             rx_valid,
  output phase_t           phase,
  output logic [OFF_W-1:0] off,
  output logic [WIN_W-1:0] win,
  output logic [SEL_W-1:0] pat_q,
  output logic             accept,
  output logic             rx_fire,
  output logic             done
);
  logic [WIN_W-1:0] nwin_q;
  logic             tx_fire;
  logic             step;
  logic             last_byte;
  logic             last_win;

  assign accept    = start && (phase == PH_IDLE);
  assign tx_fire   = ((phase == PH_FILL) || (phase == PH_CLEAR)) && tx_ready;
  assign rx_fire   = ((phase == PH_VTGT) || (phase == PH_VHOST)) && rx_valid;
  assign step      = tx_fire || rx_fire;
  assign last_byte = (off == {OFF_W{1'b1}});
  assign last_win  = (win == nwin_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      off    <= '0;
      win    <= '0;
      nwin_q <= '0;
      pat_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          nwin_q <= num_windows;
          pat_q  <= pat_sel;
          win    <= '0;
          off    <= '0;
          if (num_windows == '0) done  <= 1'b1;
          else                   phase <= PH_FILL;
        end
      end else if (step) begin
        off <= off + 1'b1;
        if (last_byte) begin
          unique case (phase)
            PH_FILL:  phase <= PH_VTGT;
            PH_VTGT:  phase <= PH_CLEAR;
            PH_CLEAR: phase <= PH_VHOST;
            PH_VHOST: begin
              if (last_win) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end else begin
                win   <= win + 1'b1;
                phase <= PH_FILL;
              end
            end
            default:  phase <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dpc_capture.sv
module dpc_capture
  import dpc_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int WIN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   rx_fire,
  input  phase_t                 phase,
  input  logic [WIN_W-1:0]       win,
  input  logic [OFF_W-1:0]       off,
  input  logic [7:0]             expected,
  input  logic [7:0]             rx_data,
  output logic [1:0]             err_code,
  output logic [WIN_W+OFF_W-1:0] err_offset,
  output logic [7:0]             err_expected,
  output logic [7:0]             err_received
);
  logic miss;
  assign miss = rx_fire && (err_code == EC_NONE) && (rx_data != expected);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code     <= EC_NONE;
      err_offset   <= '0;
      err_expected <= '0;
      err_received <= '0;
    end else if (clear) begin
      err_code     <= EC_NONE;
      err_offset   <= '0;
      err_expected <= '0;
      err_received <= '0;
    end else if (miss) begin
      err_code     <= (phase == PH_VTGT) ? EC_TXDIR : EC_RXDIR;
      err_offset   <= {win, off};
      err_expected <= expected;
      err_received <= rx_data;
    end
  end
endmodule

// File: rtl/dma_pattern_checker.sv
module dma_pattern_checker
  import dpc_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int WIN_W     = 8,
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = WIN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        pat_sel,
  input  logic [WIN_W-1:0]  num_windows,
  output logic              busy,
  output logic              done,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_zero,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] err_offset,
  output logic [7:0]        err_expected,
  output logic [7:0]        err_received
);
  phase_t           phase;
  logic [OFF_W-1:0] off;
  logic [WIN_W-1:0] win;
  logic [SEL_W-1:0] pat_q;
  logic             accept;
  logic             rx_fire;
  logic [7:0]       pat_byte;

  dpc_seq #(.OFF_W(OFF_W), .WIN_W(WIN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
    .num_windows(num_windows), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .phase(phase), .off(off), .win(win), .pat_q(pat_q),
    .accept(accept), .rx_fire(rx_fire), .done(done)
  );

  dpc_pattern #(.OFF_W(OFF_W)) u_pat (
    .sel(pat_q), .off(off), .byte_o(pat_byte)
  );

  dpc_capture #(.OFF_W(OFF_W), .WIN_W(WIN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(accept), .rx_fire(rx_fire),
    .phase(phase), .win(win), .off(off), .expected(pat_byte),
    .rx_data(rx_data), .err_code(err_code), .err_offset(err_offset),
    .err_expected(err_expected), .err_received(err_received)
  );

  assign busy     = (phase != PH_IDLE);
  assign tx_valid = (phase == PH_FILL) || (phase == PH_CLEAR);
  assign tx_zero  = (phase == PH_CLEAR);
  assign tx_data  = (phase == PH_FILL) ? pat_byte : 8'h00;
  assign rx_ready = (phase == PH_VTGT) || (phase == PH_VHOST);
endmodule

// File: rtl/dpc_sva.sv
module dpc_sva #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_zero,
  input logic              rx_ready,
  input logic [1:0]        err_code,
  input logic [ADDR_W-1:0] err_offset,
  input logic [7:0]        err_expected,
  input logic [7:0]        err_received
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zero |-> (tx_valid && tx_data == 8'h00));

  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tx_valid && !rx_ready));

  p_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_code));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'b00 && !(start && !busy)) |=>
      ($stable(err_code) && $stable(err_offset) &&
       $stable(err_expected) && $stable(err_received)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (err_code == 2'b00));
endmodule

bind dma_pattern_checker dpc_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_zero(tx_zero), .rx_ready(rx_ready), .err_code(err_code),
  .err_offset(err_offset), .err_expected(err_expected),
  .err_received(err_received)
);

// File: tb/dma_pattern_checker_tb.sv
module dma_pattern_checker_tb;
  localparam int BUF = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  pat_sel = '0;
  logic [7:0]  num_windows = '0;
  logic        busy, done, tx_valid, tx_zero, rx_ready;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  tx_data;
  logic [7:0]  rx_data = '0;
  logic [1:0]  err_code;
  logic [19:0] err_offset;
  logic [7:0]  err_expected, err_received;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dma_pattern_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
    .num_windows(num_windows), .busy(busy), .done(done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_zero(tx_zero), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .err_code(err_code), .err_offset(err_offset),
    .err_expected(err_expected), .err_received(err_received)
  );

  typedef struct packed {
    logic [2:0]  pat;
    logic [7:0]  nwin;
    logic [1:0]  bad_dir;
    logic [7:0]  bad_win;
    logic [11:0] bad_off;
    logic        bad2;
    logic        stall;
    logic        busy_start;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 8'd1, 2'd0, 8'd0, 12'h000, 1'b0, 1'b0, 1'b0},
    '{3'd1, 8'd1, 2'd1, 8'd0, 12'h013, 1'b0, 1'b0, 1'b0},
    '{3'd2, 8'd2, 2'd2, 8'd1, 12'hFFF, 1'b0, 1'b0, 1'b0},
    '{3'd3, 8'd1, 2'd0, 8'd0, 12'h000, 1'b0, 1'b0, 1'b1},
    '{3'd4, 8'd1, 2'd1, 8'd0, 12'h000, 1'b1, 1'b0, 1'b0},
    '{3'd5, 8'd1, 2'd0, 8'd0, 12'h000, 1'b0, 1'b0, 1'b0},
    '{3'd6, 8'd1, 2'd2, 8'd0, 12'h7FE, 1'b0, 1'b1, 1'b0},
    '{3'd7, 8'd1, 2'd0, 8'd0, 12'h000, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [7:0] model_byte(input int p, input int o);
    logic [31:0] word;
    int          run;
    logic [7:0]  first;
    if (p < 4) begin
      run   = (p < 2) ? 16 : 32;
      first = (p % 2 == 1) ? 8'hFF : 8'h00;
      return ((o / run) % 2 == 1) ? ~first : first;
    end
    if (p == 4) return 8'h00;
    if (p == 5) return 8'hFF;
    word = (p == 6) ? 32'hAA55AA55 : 32'h55AA55AA;
    return word[8*(o%4) +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int         txn = 0;
    int         rxn = 0;
    int         txbad = 0;
    int         zbad = 0;
    int         cyc = 0;
    int         last_rx = -10;
    int         done_cyc = -1;
    int         ph, w, o;
    logic [7:0] d;
    logic [7:0] exp_b;
    int         n = int'(v.nwin);
    @(negedge clk);
    pat_sel = v.pat; num_windows = v.nwin; start = 1'b1;
    while (done_cyc < 0 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (v.busy_start && cyc == 100) begin
        start = 1'b1; pat_sel = ~v.pat; num_windows = 8'd3;
      end
      if (done) done_cyc = cyc;
      else begin
        tx_ready = !(v.stall && (cyc % 4 == 3));
        if (tx_valid && tx_ready) begin
          ph = (txn / BUF) % 2; o = txn % BUF;
          exp_b = (ph == 1) ? 8'h00 : model_byte(int'(v.pat), o);
          if (tx_data !== exp_b) txbad++;
          if (tx_zero !== ph[0]) zbad++;
          txn++;
        end
        rx_valid = !(v.stall && (cyc % 4 == 1));
        ph = (rxn / BUF) % 2; w = rxn / (2*BUF); o = rxn % BUF;
        d = model_byte(int'(v.pat), o);
        if (v.bad_dir == 2'd1 && ph == 0 && w == int'(v.bad_win) && o == int'(v.bad_off)) d = d ^ 8'h3C;
        if (v.bad_dir == 2'd2 && ph == 1 && w == int'(v.bad_win) && o == int'(v.bad_off)) d = d ^ 8'h3C;
        if (v.bad2 && ph == 1 && w == n - 1 && o == 5) d = d ^ 8'h0F;
        rx_data = d;
        if (rx_ready && rx_valid) begin rxn++; last_rx = cyc; end
      end
    end
    tx_ready = 1'b0; rx_valid = 1'b0;
    chk(txbad == 0, (v.pat >= 6) ? "R2" : "R1", "pattern bytes wrong", txbad, 0);
    chk(zbad == 0, "R3", "tx_zero marking wrong", zbad, 0);
    chk(txn == n*2*BUF, v.busy_start ? "R9" : "R5", "tx byte total", txn, n*2*BUF);
    chk(rxn == n*2*BUF, "R3", "rx byte total", rxn, n*2*BUF);
    chk(done_cyc == last_rx + 1, "R6", "done cycle vs last rx", done_cyc, last_rx + 1);
    chk(busy == 1'b0, "R6", "busy after done", busy, 0);
    if (v.bad_dir == 2'd0) begin
      chk(err_code == 2'b00, "R9", "err_code on clean run", err_code, 0);
    end else begin
      exp_b = model_byte(int'(v.pat), int'(v.bad_off));
      chk(err_code == ((v.bad_dir == 2'd1) ? 2'b01 : 2'b10), "R7", "err_code",
          err_code, (v.bad_dir == 2'd1) ? 1 : 2);
      chk(int'(err_offset) == int'(v.bad_win)*BUF + int'(v.bad_off),
          v.bad2 ? "R8" : "R7", "err_offset", err_offset,
          int'(v.bad_win)*BUF + int'(v.bad_off));
      chk(err_expected == exp_b, "R7", "err_expected", err_expected, exp_b);
      chk(err_received == (exp_b ^ 8'h3C), v.bad2 ? "R8" : "R7", "err_received",
          err_received, exp_b ^ 8'h3C);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R10", "busy/done after reset", {busy, done}, 0);
    chk(tx_valid == 0 && rx_ready == 0, "R10", "stream flags after reset",
        {tx_valid, rx_ready}, 0);
    chk(err_code == 2'b00, "R10", "err_code after reset", err_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: zero windows gives done the next cycle with no transfer
    num_windows = 8'd0; pat_sel = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R6", "done after zero-window start", done, 1);
    chk(tx_valid == 1'b0 && busy == 1'b0, "R6", "no transfer on zero windows",
        {tx_valid, busy}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done lasts one cycle", done, 0);
    for (int i = 0; i < 8; i++) run_vec(VECS[i]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule